// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

A single timer channel with a small word-addressed register interface. Software stores a limit value and selects an operating form through a control register. While enabled, the counter decrements once per prescaled tick. When it steps from one to zero it sets a raw interrupt flag.

In the repeating forms the counter reloads on the tick after it reaches zero. One-shot form parks the counter at zero instead. A free-running form ignores the stored limit and reloads the full-scale value of the selected width, which is 16 or 32 bits. A second limit register updates the limit without disturbing the count that is in progress.

The interrupt output is a level: the raw flag qualified by an enable bit. The flag stays set until software writes the clear register. Reads are combinational from the registers and have no side effects.

Top module: `intv_timer`

## Requirements
- R1: After reset the control register reads 0x20 (interrupt enable only, timer disabled). The limit, current value and raw flag read 0, and `irq` is low.
- R2: The word index is the byte address shifted right by 2. The indices are 0 load, 1 current value, 2 control, 3 interrupt clear, 4 raw status, 5 masked status and 6 background load. Indices 0 and 6 both read the stored limit. Index 3, index 7 and any byte address of 32 or above read 0.
- R3: A write to index 0 stores the limit and, in the same clock, loads the counter with the reload value that the current control selects.
- R4: A write to index 6 stores the limit and leaves the counter unchanged. The new limit is used at the next reload.
- R5: The counter steps only on ticks. Control bits 3:2 select the prescale: 00 gives one tick per clock, 01 one every 16 clocks, 10 one every 256 clocks, and 11 one per clock. The prescaler restarts on every control write and is held while the timer is disabled.
- R6: A tick at count 1 sets the raw flag and gives count 0. In the repeating forms the next tick at count 0 loads the reload value, so one period lasts reload+1 ticks.
- R7: With control bit 0 (one-shot) set, a count of 0 stays at 0 and raises no further expiries.
- R8: With control bits 0 and 6 both clear (free-running), the reload value is 0xFFFF when control bit 1 is clear and 0xFFFFFFFF when it is set. This also applies to load writes.
- R9: With control bit 1 clear (16-bit size), the counter and the reload value use only the low 16 bits, and the current value reads 0 in its upper 16 bits.
- R10: Any write to index 3 clears the raw flag. If an expiry occurs in the same clock, the flag is set.
- R11: Masked status and `irq` equal the raw flag ANDed with control bit 5 (interrupt enable). Raw status does not depend on bit 5.
- R12: Writes to index 1, index 7, and byte addresses of 32 or above change no register.
- R13: A control write stores bits 7:5 and 3:0, and bit 4 reads 0. It keeps the count, trimmed to the new width. While control bit 7 (enable) is clear, the count does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data, valid while bus_sel is high and bus_wr is low, 0 otherwise |
| irq | output | 1 | Level interrupt |

## Verification
The counter is driven through each operating form and compared on every clock against a reference model. The repeating form with a small limit separates the load-then-expire timing from an off-by-one reload. A background-load write in the middle of a period shows that the count is not restarted. One-shot form shows the counter parking at zero, and a 16-bit free-running form, run through a full wrap, confirms the 0xFFFF reload and the masking of the upper bits. The three prescale codes and the reserved fourth code separate tick spacing from count behaviour. Interrupt clears written in the same cycles as expiries confirm that an expiry takes priority over the clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // control register layout, bit 7 down to bit 0
    typedef struct packed {
        logic       en;        // 7
        logic       periodic;  // 6
        logic       ie;        // 5
        logic       rsv;       // 4
        logic [1:0] pre_sel;   // 3:2
        logic       wide;      // 1
        logic       oneshot;   // 0
    } ctrl_t;

    localparam logic [7:0] CTRL_RESET = 8'h20;
    localparam logic [7:0] CTRL_KEEP  = 8'hEF;

    localparam logic [1:0] PRE_DIV16  = 2'b01;
    localparam logic [1:0] PRE_DIV256 = 2'b10;

    localparam logic [2:0] W_LOAD   = 3'd0;
    localparam logic [2:0] W_VALUE  = 3'd1;
    localparam logic [2:0] W_CTRL   = 3'd2;
    localparam logic [2:0] W_CLR    = 3'd3;
    localparam logic [2:0] W_RAW    = 3'd4;
    localparam logic [2:0] W_MASKED = 3'd5;
    localparam logic [2:0] W_BGLOAD = 3'd6;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int MID_LOG  = 4,
    parameter int SLOW_LOG = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);
    import tmr_pkg::*;

    typedef struct packed {
        logic [SLOW_LOG-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run && !restart) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
        case (sel)
            PRE_DIV16:  tick = run && (&st_q.cnt[MID_LOG-1:0]);
            PRE_DIV256: tick = run && (&st_q.cnt);
            default:    tick = run;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             oneshot,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             load_now,
    input  logic [CNT_W-1:0] load_val,
    input  logic             trim_now,
    input  logic [CNT_W-1:0] trim_mask,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             raw
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             raw;
    } cnt_t;

    cnt_t st_d, st_q;
    logic expire;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (tick) begin
            if (st_q.count == '0) begin
                if (!oneshot) begin
                    st_d.count = reload_val;
                end
            end else begin
                st_d.count = st_q.count - 1'b1;
                expire     = (st_q.count == {{(CNT_W-1){1'b0}}, 1'b1});
            end
        end
        if (load_now) begin
            st_d.count = load_val;
        end else if (trim_now) begin
            st_d.count = st_d.count & trim_mask;
        end
        if (clr) begin
            st_d.raw = 1'b0;
        end
        if (expire) begin
            st_d.raw = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.count;
    assign raw   = st_q.raw;

endmodule

// File: rtl/intv_timer.sv
module intv_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16,
    parameter int ADDR_W   = 12,
    parameter int MID_LOG  = 4,
    parameter int SLOW_LOG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int IDX_W   = 3;
    localparam int MAP_TOP = IDX_W + 2;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] limit;
    } regs_t;

    function automatic logic [CNT_W-1:0] width_mask(input logic wide);
        if (wide) begin
            return '1;
        end
        return {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    endfunction

    regs_t            rg_d, rg_q;
    ctrl_t            ctrl_q;
    ctrl_t            ctrl_new;
    logic             in_map;
    logic [IDX_W-1:0] word;
    logic             wr_go;
    logic             load_wr, ctrl_wr, clr_wr, bg_wr;
    logic             free_run;
    logic [CNT_W-1:0] cur_mask;
    logic [CNT_W-1:0] reload_cur;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] trim_mask;
    logic             tick;
    logic [CNT_W-1:0] count_q;
    logic             raw_q;

    assign ctrl_q   = rg_q.ctrl;
    assign in_map   = (bus_addr[ADDR_W-1:MAP_TOP] == '0);
    assign word     = bus_addr[MAP_TOP-1:2];
    assign wr_go    = bus_sel && bus_wr && in_map;
    assign load_wr  = wr_go && (word == W_LOAD);
    assign ctrl_wr  = wr_go && (word == W_CTRL);
    assign clr_wr   = wr_go && (word == W_CLR);
    assign bg_wr    = wr_go && (word == W_BGLOAD);
    assign ctrl_new = ctrl_t'(bus_wdata[7:0] & CTRL_KEEP);

    always_comb begin
        free_run   = !ctrl_q.oneshot && !ctrl_q.periodic;
        cur_mask   = width_mask(ctrl_q.wide);
        reload_cur = free_run ? cur_mask : (rg_q.limit & cur_mask);
        load_val   = free_run ? cur_mask : (bus_wdata & cur_mask);
        trim_mask  = width_mask(ctrl_new.wide);
    end

    always_comb begin
        rg_d = rg_q;
        if (load_wr || bg_wr) begin
            rg_d.limit = bus_wdata;
        end
        if (ctrl_wr) begin
            rg_d.ctrl = ctrl_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q.ctrl  <= ctrl_t'(CTRL_RESET);
            rg_q.limit <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    tmr_prescale #(
        .MID_LOG (MID_LOG),
        .SLOW_LOG(SLOW_LOG)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctrl_q.en),
        .restart(ctrl_wr),
        .sel    (ctrl_q.pre_sel),
        .tick   (tick)
    );

    tmr_count #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .oneshot   (ctrl_q.oneshot),
        .reload_val(reload_cur),
        .load_now  (load_wr),
        .load_val  (load_val),
        .trim_now  (ctrl_wr),
        .trim_mask (trim_mask),
        .clr       (clr_wr),
        .count     (count_q),
        .raw       (raw_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && in_map) begin
            case (word)
                W_LOAD, W_BGLOAD: bus_rdata = rg_q.limit;
                W_VALUE:          bus_rdata = count_q;
                W_CTRL:           bus_rdata = {{(CNT_W-8){1'b0}}, ctrl_q};
                W_RAW:            bus_rdata = {{(CNT_W-1){1'b0}}, raw_q};
                W_MASKED:         bus_rdata = {{(CNT_W-1){1'b0}}, raw_q && ctrl_q.ie};
                default:          bus_rdata = '0;
            endcase
        end
    end

    assign irq = raw_q && ctrl_q.ie;

endmodule

// File: rtl/intv_timer_checker.sv
module intv_timer_checker #(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [7:0]       ctrl,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic             raw,
    input logic             clr_wr,
    input logic             load_wr,
    input logic             ctrl_wr
);
    AST_RESET_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl == 8'h20 && count == '0 && !raw)); // R1

    AST_EXPIRE_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == {{(CNT_W-1){1'b0}}, 1'b1}) |=> raw); // R6

    AST_ONESHOT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctrl[0] && count == '0 && !load_wr && !ctrl_wr) |=> (count == '0)); // R7

    AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[1] |-> (count[CNT_W-1:NARROW_W] == '0)); // R9

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !(tick && count == {{(CNT_W-1){1'b0}}, 1'b1})) |=> !raw); // R10

    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[7] && !(bus_sel && bus_wr)) |=> $stable(count)); // R13

endmodule

bind intv_timer intv_timer_checker #(
    .CNT_W   (CNT_W),
    .NARROW_W(NARROW_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_sel(bus_sel),
    .bus_wr (bus_wr),
    .ctrl   (ctrl_q),
    .tick   (tick),
    .count  (count_q),
    .raw    (raw_q),
    .clr_wr (clr_wr),
    .load_wr(load_wr),
    .ctrl_wr(ctrl_wr)
);

// File: tb/intv_timer_test.sv
module intv_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0]  m_ctrl;
    logic [31:0] m_limit, m_count;
    int          m_pre;
    logic        m_raw;

    intv_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 8'h20; m_limit = 0; m_count = 0; m_pre = 0; m_raw = 0;
        end else begin
            logic [31:0] msk, rel, nc;
            logic fr, tk, ex, nraw;
            int dv, npre;
            msk = m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
            fr  = !m_ctrl[0] && !m_ctrl[6];
            rel = fr ? msk : (m_limit & msk);
            dv  = (m_ctrl[3:2] == 2'b01) ? 16 : (m_ctrl[3:2] == 2'b10) ? 256 : 1;
            tk  = m_ctrl[7] && ((m_pre % dv) == dv - 1);
            ex  = 0; nc = m_count; nraw = m_raw;
            if (tk) begin
                if (m_count == 0) begin
                    if (!m_ctrl[0]) nc = rel;
                end else begin
                    nc = m_count - 1; ex = (m_count == 1);
                end
            end
            npre = m_ctrl[7] ? (m_pre + 1) % 256 : 0;
            if (bus_sel && bus_wr && bus_addr < 12'd32) begin
                case (bus_addr[4:2])
                    3'd0: begin m_limit = bus_wdata; nc = fr ? msk : (bus_wdata & msk); end
                    3'd2: begin
                        m_ctrl = bus_wdata[7:0] & 8'hEF; npre = 0;
                        nc = nc & (bus_wdata[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF);
                    end
                    3'd3: nraw = 0;
                    3'd6: m_limit = bus_wdata;
                    default: ;
                endcase
            end
            if (ex) nraw = 1;
            m_count = nc; m_pre = npre; m_raw = nraw;
        end
    end

    function automatic logic [31:0] exp_read();
        if (!bus_sel || bus_wr || bus_addr >= 12'd32) return 0;
        case (bus_addr[4:2])
            3'd0, 3'd6: return m_limit;
            3'd1:       return m_count;
            3'd2:       return {24'd0, m_ctrl};
            3'd4:       return {31'd0, m_raw};
            3'd5:       return {31'd0, m_raw & m_ctrl[5]};
            default:    return 0;
        endcase
    endfunction

    task automatic cyc(input logic w, input logic [11:0] a, input logic [31:0] d, input string tag);
        logic [31:0] er;
        logic ei;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1;
        er = exp_read();
        ei = m_raw & m_ctrl[5];
        vectors++;
        if (bus_rdata !== er || irq !== ei) begin
            fails++;
            $display("FAIL %s addr=%h rdata=%h exp=%h irq=%b exp=%b", tag, a, bus_rdata, er, irq, ei);
        end
    endtask

    task automatic run(input int n, input logic [11:0] a, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, a, 32'd0, tag);
    endtask

    initial begin
        #(10 * 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R2 map and unmapped reads
        for (int k = 0; k < 8; k++) cyc(1'b0, 12'(k * 4), 0, "R1");
        cyc(1'b0, 12'h040, 0, "R2");
        cyc(1'b0, 12'hF00, 0, "R2");
        cyc(1'b0, 12'h00C, 0, "R2");
        // R8 load write while free-running loads full scale
        cyc(1'b1, 12'h000, 32'd5, "R8");
        cyc(1'b0, 12'h004, 0, "R8");
        cyc(1'b0, 12'h018, 0, "R2");
        // R3 R6 R11 periodic, 32-bit, divide 1
        cyc(1'b1, 12'h008, 32'hE2, "R13");
        cyc(1'b1, 12'h000, 32'd5, "R3");
        run(14, 12'h004, "R6");
        cyc(1'b0, 12'h010, 0, "R11");
        cyc(1'b0, 12'h014, 0, "R11");
        // R10 clear, R12 ignored writes
        cyc(1'b1, 12'h00C, 32'd0, "R10");
        cyc(1'b0, 12'h010, 0, "R10");
        cyc(1'b1, 12'h004, 32'h1234, "R12");
        cyc(1'b0, 12'h004, 0, "R12");
        cyc(1'b1, 12'h01C, 32'hFFFF, "R12");
        cyc(1'b1, 12'h080, 32'hFFFF, "R12");
        cyc(1'b0, 12'h000, 0, "R12");
        cyc(1'b0, 12'h008, 0, "R12");
        // R4 background load
        cyc(1'b1, 12'h018, 32'd2, "R4");
        run(12, 12'h004, "R4");
        cyc(1'b0, 12'h000, 0, "R4");
        // R7 one-shot
        cyc(1'b1, 12'h00C, 0, "R10");
        cyc(1'b1, 12'h008, 32'hA3, "R7");
        cyc(1'b1, 12'h000, 32'd2, "R7");
        run(8, 12'h004, "R7");
        cyc(1'b1, 12'h00C, 0, "R7");
        run(4, 12'h010, "R7");
        // R11 interrupt enable off
        cyc(1'b1, 12'h008, 32'hC2, "R11");
        cyc(1'b1, 12'h000, 32'd2, "R11");
        run(5, 12'h014, "R11");
        run(2, 12'h010, "R11");
        // R5 prescale codes
        cyc(1'b1, 12'h008, 32'hE6, "R5");
        cyc(1'b1, 12'h000, 32'd2, "R5");
        run(60, 12'h004, "R5");
        cyc(1'b1, 12'h008, 32'hEA, "R5");
        cyc(1'b1, 12'h000, 32'd1, "R5");
        run(600, 12'h004, "R5");
        cyc(1'b1, 12'h008, 32'hEE, "R5");
        cyc(1'b1, 12'h000, 32'd3, "R5");
        run(10, 12'h004, "R5");
        // R10 clear racing expiries
        cyc(1'b1, 12'h008, 32'hE2, "R10");
        cyc(1'b1, 12'h000, 32'd1, "R10");
        for (int k = 0; k < 8; k++) cyc(1'b1, 12'h00C, 0, "R10");
        // R13 trim on width change, freeze, stored bits
        cyc(1'b1, 12'h000, 32'h0001_2345, "R13");
        cyc(1'b1, 12'h008, 32'hE0, "R9");
        cyc(1'b0, 12'h004, 0, "R9");
        cyc(1'b1, 12'h008, 32'h60, "R13");
        run(5, 12'h004, "R13");
        cyc(1'b1, 12'h008, 32'hFF, "R13");
        cyc(1'b0, 12'h008, 0, "R13");
        // R8 R9 16-bit free-run through a full wrap
        cyc(1'b1, 12'h008, 32'hA0, "R8");
        cyc(1'b1, 12'h000, 32'd7, "R9");
        run(65540, 12'h004, "R8");
        cyc(1'b0, 12'h010, 0, "R8");
        // R8 32-bit free-run
        cyc(1'b1, 12'h008, 32'h82, "R8");
        cyc(1'b1, 12'h000, 32'd7, "R8");
        run(4, 12'h004, "R8");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule